// File: doc/BRIEF.md
# Raster Display Timing Generator

This block walks a raster display through its lines and frames, one step per pixel-clock enable, and drives the horizontal sync, vertical sync, data-enable and the pixel coordinates of the active area. Each axis is split into five consecutive phases: a lead-in gap before sync, the sync pulse, the back porch, the active span and the front porch. The horizontal axis counts pixels. The vertical axis counts lines with the same five-phase pattern.

Software programs the phases through a small write port. Every configuration word carries the horizontal value in its low half and the vertical value in its high half, so each write sets both axes at once. Writes land in a pending bank. The live bank copies the pending bank only at the boundary between two frames, so a frame never mixes two timings. The active width and height are limited to 1366 × 768.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset is held, and after reset until the first enabled step, the position is at the very start of a frame: hsync, vsync and de are 0, and x and y are 0. The default timing comes from parameters.
- R2: A line runs through its phases in this order: lead-in, sync, back porch, active, front porch. Its length in enabled steps is the sum of the five horizontal values. A frame is the same in lines, using the vertical values.
- R3: hsync is 1 exactly while the horizontal position is inside the sync phase (active-high).
- R4: vsync is 1 for every pixel of every line whose line index is inside the vertical sync phase. The line index advances once at the last pixel of each line.
- R5: de is 1 only while both axes are in their active phases. It is never 1 together with hsync or vsync.
- R6: While de is 1, x and y give the position inside the active area, counted from 0. While de is 0, both read 0.
- R7: A cycle with pix_en low changes no output and no position.
- R8: Write word layout: bits 15:0 hold the horizontal value and bits 31:16 hold the vertical value. Selects 0 = lead-in, 1 = sync, 2 = back porch, 3 = front porch, 4 = active size (width low, height high). Selects 5 to 7 are ignored.
- R9: Written values take effect only from the first pixel of the frame that follows the current one.
- R10: A written width above 1366 acts as 1366, and a written height above 768 acts as 768.
- R11: Any interval may be 0. Its phase is then skipped, and a line made only of active pixels keeps de high across the line boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Parameter select |
| cfg_wdata | input | 32 | Packed value: horizontal in 15:0, vertical in 31:16 |
| pix_en | input | 1 | Pixel-clock enable; one step per high cycle |
| hsync | output | 1 | Horizontal sync, active-high |
| vsync | output | 1 | Vertical sync, active-high |
| de | output | 1 | Data enable |
| x | output | 16 | Active-area column |
| y | output | 16 | Active-area row |

## Verification
The hardest case to reach is a write that arrives inside a frame and must stay invisible until the frame ends. The write is most telling when it lands in the same cycle as the last pixel of a frame, where the live bank takes the old pending value while the pending bank takes the new one. The stimulus produces this case by scattering random writes, including writes to unused selects, through frames of random short timing with a gappy pix_en. Directed frames add the cases that random values rarely hit: every blanking interval set to zero, and oversize width and height that the block must clamp.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
   localparam int RTG_FW = 16;           // one axis field in a config word
   localparam int RTG_AW = RTG_FW + 3;   // holds the sum of five fields

   typedef logic [RTG_FW-1:0] rtg_len_t;

   typedef struct packed {
      rtg_len_t lead;
      rtg_len_t sync;
      rtg_len_t back;
      rtg_len_t front;
      rtg_len_t act;
   } rtg_axis_cfg_t;

   typedef enum logic [2:0] {
      SEL_LEAD  = 3'd0,
      SEL_SYNC  = 3'd1,
      SEL_BACK  = 3'd2,
      SEL_FRONT = 3'd3,
      SEL_ACT   = 3'd4
   } rtg_sel_e;

   typedef enum logic [2:0] {
      PH_LEAD, PH_SYNC, PH_BACK, PH_ACT, PH_FRONT
   } rtg_phase_e;
endpackage

// File: rtl/rtg_cfg_bank.sv
module rtg_cfg_bank
   import rtg_pkg::*;
#(
   parameter int DEF_H_LEAD  = 1,
   parameter int DEF_H_SYNC  = 2,
   parameter int DEF_H_BACK  = 3,
   parameter int DEF_H_FRONT = 2,
   parameter int DEF_H_ACT   = 8,
   parameter int DEF_V_LEAD  = 1,
   parameter int DEF_V_SYNC  = 1,
   parameter int DEF_V_BACK  = 1,
   parameter int DEF_V_FRONT = 1,
   parameter int DEF_V_ACT   = 4,
   parameter int MAX_W       = 1366,
   parameter int MAX_H       = 768
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [2:0]          wr_sel,
   input  logic [2*RTG_FW-1:0] wr_data,
   input  logic                apply,
   output rtg_axis_cfg_t       live_h,
   output rtg_axis_cfg_t       live_v
);
   for (genvar ax = 0; ax < 2; ax++) begin : g_axis
      localparam int LIMIT = (ax == 0) ? MAX_W : MAX_H;
      localparam rtg_axis_cfg_t DEF = (ax == 0) ?
         '{lead: rtg_len_t'(DEF_H_LEAD), sync: rtg_len_t'(DEF_H_SYNC),
           back: rtg_len_t'(DEF_H_BACK), front: rtg_len_t'(DEF_H_FRONT),
           act: rtg_len_t'(DEF_H_ACT)} :
         '{lead: rtg_len_t'(DEF_V_LEAD), sync: rtg_len_t'(DEF_V_SYNC),
           back: rtg_len_t'(DEF_V_BACK), front: rtg_len_t'(DEF_V_FRONT),
           act: rtg_len_t'(DEF_V_ACT)};

      rtg_len_t      half;
      rtg_len_t      half_lim;
      rtg_axis_cfg_t pend;
      rtg_axis_cfg_t live;

      assign half     = wr_data[ax*RTG_FW +: RTG_FW];
      assign half_lim = (half > rtg_len_t'(LIMIT)) ? rtg_len_t'(LIMIT) : half;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend <= DEF;
            live <= DEF;
         end else begin
            if (apply)
               live <= pend;
            if (wr_en) begin
               case (rtg_sel_e'(wr_sel))
                  SEL_LEAD:  pend.lead  <= half;
                  SEL_SYNC:  pend.sync  <= half;
                  SEL_BACK:  pend.back  <= half;
                  SEL_FRONT: pend.front <= half;
                  SEL_ACT:   pend.act   <= half_lim;
                  default:   ;
               endcase
            end
         end
      end

      if (ax == 0) begin : g_h
         assign live_h = live;
      end else begin : g_v
         assign live_v = live;
      end
   end
endmodule

// File: rtl/rtg_axis_seq.sv
module rtg_axis_seq
   import rtg_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  rtg_axis_cfg_t cfg,
   output logic          at_last,
   output logic          in_sync,
   output logic          in_act,
   output rtg_len_t      coord
);
   logic [RTG_AW-1:0] pos;
   logic [RTG_AW-1:0] e_lead, e_sync, e_back, e_act, e_total;
   rtg_phase_e        phase;

   // phase boundaries, each the running sum of the intervals before it
   assign e_lead  = RTG_AW'(cfg.lead);
   assign e_sync  = e_lead + RTG_AW'(cfg.sync);
   assign e_back  = e_sync + RTG_AW'(cfg.back);
   assign e_act   = e_back + RTG_AW'(cfg.act);
   assign e_total = e_act  + RTG_AW'(cfg.front);

   assign at_last = (pos + 1'b1) >= e_total;

   always_comb begin
      if (pos < e_lead)      phase = PH_LEAD;
      else if (pos < e_sync) phase = PH_SYNC;
      else if (pos < e_back) phase = PH_BACK;
      else if (pos < e_act)  phase = PH_ACT;
      else                   phase = PH_FRONT;
   end

   assign in_sync = (phase == PH_SYNC);
   assign in_act  = (phase == PH_ACT);
   assign coord   = rtg_len_t'(pos - e_back);

   always_ff @(posedge clk) begin
      if (!rst_n)
         pos <= '0;
      else if (step)
         pos <= at_last ? '0 : pos + 1'b1;
   end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
   import rtg_pkg::*;
#(
   parameter int DEF_H_LEAD  = 1,
   parameter int DEF_H_SYNC  = 2,
   parameter int DEF_H_BACK  = 3,
   parameter int DEF_H_FRONT = 2,
   parameter int DEF_H_ACT   = 8,
   parameter int DEF_V_LEAD  = 1,
   parameter int DEF_V_SYNC  = 1,
   parameter int DEF_V_BACK  = 1,
   parameter int DEF_V_FRONT = 1,
   parameter int DEF_V_ACT   = 4,
   parameter int MAX_W       = 1366,
   parameter int MAX_H       = 768
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic [2:0]  cfg_sel,
   input  logic [31:0] cfg_wdata,
   input  logic        pix_en,
   output logic        hsync,
   output logic        vsync,
   output logic        de,
   output logic [15:0] x,
   output logic [15:0] y
);
   if (MAX_W < 1 || MAX_W >= (1 << RTG_FW)) begin : g_bad_w
      $error("MAX_W out of field range");
   end
   if (MAX_H < 1 || MAX_H >= (1 << RTG_FW)) begin : g_bad_h
      $error("MAX_H out of field range");
   end
   if (DEF_H_ACT > MAX_W || DEF_V_ACT > MAX_H) begin : g_bad_def
      $error("default active size exceeds the limit");
   end

   rtg_axis_cfg_t live_h, live_v;
   logic          h_last, h_sync, h_act;
   logic          v_last, v_sync, v_act;
   rtg_len_t      h_coord, v_coord;
   logic          v_step, frame_end;

   assign v_step    = pix_en & h_last;
   assign frame_end = v_step & v_last;

   rtg_cfg_bank #(
      .DEF_H_LEAD(DEF_H_LEAD), .DEF_H_SYNC(DEF_H_SYNC), .DEF_H_BACK(DEF_H_BACK),
      .DEF_H_FRONT(DEF_H_FRONT), .DEF_H_ACT(DEF_H_ACT),
      .DEF_V_LEAD(DEF_V_LEAD), .DEF_V_SYNC(DEF_V_SYNC), .DEF_V_BACK(DEF_V_BACK),
      .DEF_V_FRONT(DEF_V_FRONT), .DEF_V_ACT(DEF_V_ACT),
      .MAX_W(MAX_W), .MAX_H(MAX_H)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_sel(cfg_sel),
      .wr_data(cfg_wdata), .apply(frame_end),
      .live_h(live_h), .live_v(live_v)
   );

   rtg_axis_seq u_hseq (
      .clk(clk), .rst_n(rst_n), .step(pix_en), .cfg(live_h),
      .at_last(h_last), .in_sync(h_sync), .in_act(h_act), .coord(h_coord)
   );

   rtg_axis_seq u_vseq (
      .clk(clk), .rst_n(rst_n), .step(v_step), .cfg(live_v),
      .at_last(v_last), .in_sync(v_sync), .in_act(v_act), .coord(v_coord)
   );

   assign hsync = h_sync;
   assign vsync = v_sync;
   assign de    = h_act & v_act;
   assign x     = de ? h_coord : '0;
   assign y     = de ? v_coord : '0;
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker #(
   parameter int MAX_W = 1366,
   parameter int MAX_H = 768
) (
   input logic        clk,
   input logic        rst_n,
   input logic        pix_en,
   input logic        hsync,
   input logic        vsync,
   input logic        de,
   input logic [15:0] x,
   input logic [15:0] y
);
   a_r7_hold_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_en |=> $stable({hsync, vsync, de, x, y}));

   a_r6_zero_outside_active: assert property (@(posedge clk) disable iff (!rst_n)
      !de |-> (x == 16'd0 && y == 16'd0));

   a_r5_de_excludes_sync: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> (!hsync && !vsync));

   a_r10_coord_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> (32'(x) < MAX_W && 32'(y) < MAX_H));

   a_r6_x_advances: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_en && de) |=> (!de || x == $past(x) + 16'd1 || x == 16'd0));
endmodule

bind raster_timing_gen rtg_checker #(.MAX_W(MAX_W), .MAX_H(MAX_H)) u_chk (
   .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .hsync(hsync), .vsync(vsync),
   .de(de), .x(x), .y(y)
);

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic        pix_en = 1'b0;
   logic        hsync, vsync, de;
   logic [15:0] x, y;

   int checks = 0, errors = 0, frames = 0, cyc = 0;
   int lv[2][5];   // live model timing, index = select code
   int pd[2][5];   // pending model timing
   int hp = 0, vp = 0, maxx = 0, maxy = 0;
   bit done = 0;
   string scen = "init";

   always #5 clk = ~clk;

   raster_timing_gen u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .pix_en(pix_en), .hsync(hsync), .vsync(vsync),
      .de(de), .x(x), .y(y)
   );

   function automatic int total(int ax);
      return lv[ax][0] + lv[ax][1] + lv[ax][2] + lv[ax][3] + lv[ax][4];
   endfunction

   // phase code: 0 lead, 1 sync, 2 back, 3 active, 4 front
   function automatic int phase(int ax, int p);
      int a = lv[ax][0];
      int b = a + lv[ax][1];
      int c = b + lv[ax][2];
      int d = c + lv[ax][4];
      if (p < a) return 0;
      if (p < b) return 1;
      if (p < c) return 2;
      if (p < d) return 3;
      return 4;
   endfunction

   function automatic int coord(int ax, int p);
      return p - (lv[ax][0] + lv[ax][1] + lv[ax][2]);
   endfunction

   task automatic cmp(string req, string nm, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s [%s] %s actual=%0d expected=%0d", req, scen, nm, act, exp);
      end
   endtask

   task automatic check_outputs();
      bit ede = (phase(0, hp) == 3) && (phase(1, vp) == 3);
      cmp("R3", "hsync", int'(hsync), int'(phase(0, hp) == 1));
      cmp("R4", "vsync", int'(vsync), int'(phase(1, vp) == 1));
      cmp("R5", "de", int'(de), int'(ede));
      cmp("R6", "x", int'(x), ede ? coord(0, hp) : 0);
      cmp("R6", "y", int'(y), ede ? coord(1, vp) : 0);
      if (de) begin
         if (int'(x) > maxx) maxx = int'(x);
         if (int'(y) > maxy) maxy = int'(y);
      end
   endtask

   task automatic step(bit en, bit we, int sel, logic [31:0] data);
      bit fe;
      pix_en = en; cfg_we = we; cfg_sel = sel[2:0]; cfg_wdata = data;
      @(posedge clk);
      fe = en && hp == total(0) - 1 && vp == total(1) - 1;
      if (en) begin
         if (hp >= total(0) - 1) begin
            hp = 0;
            if (vp >= total(1) - 1) vp = 0; else vp++;
         end else hp++;
      end
      if (fe) begin
         lv = pd;
         frames++;
      end
      if (we && sel < 5) begin
         for (int ax = 0; ax < 2; ax++) begin
            int v = ax ? int'(data[31:16]) : int'(data[15:0]);
            if (sel == 4) v = (v > (ax ? 768 : 1366)) ? (ax ? 768 : 1366) : v;
            pd[ax][sel] = v;
         end
      end
      @(negedge clk);
      cfg_we = 1'b0;
      check_outputs();
   endtask

   task automatic wr(int sel, int h, int v);
      step($urandom_range(0, 3) != 0, 1'b1, sel, {v[15:0], h[15:0]});
   endtask

   task automatic run_frames(int n, bit steady);
      int start = frames;
      while (frames < start + n)
         step(steady ? 1'b1 : ($urandom_range(0, 3) != 0), 1'b0, 0, 32'd0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000 && !done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected=<190000 cycles", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int seed;
      logic [15:0] sx, sy;
      logic sh, sv, sd;
      seed = $urandom(32'd7723);
      // defaults: h lead 1 sync 2 back 3 front 2 act 8; v lead 1 sync 1 back 1 front 1 act 4
      lv[0] = '{1, 2, 3, 2, 8};
      lv[1] = '{1, 1, 1, 1, 4};
      pd = lv;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      scen = "R1";
      cmp("R1", "hsync", int'(hsync), 0);
      cmp("R1", "vsync", int'(vsync), 0);
      cmp("R1", "de", int'(de), 0);
      cmp("R1", "x", int'(x), 0);
      cmp("R1", "y", int'(y), 0);
      rst_n = 1'b1;
      step(1'b0, 1'b0, 0, 32'd0);
      cmp("R1", "de after reset", int'(de), 0);

      // R2: default timing, two full frames with a steady enable
      scen = "R2";
      run_frames(2, 1'b1);
      cmp("R2", "frames in 256 steps", frames, 2);

      // R7: freeze with pix_en low
      scen = "R7";
      repeat (7) step(1'b1, 1'b0, 0, 32'd0);
      sx = x; sy = y; sh = hsync; sv = vsync; sd = de;
      for (int i = 0; i < 5; i++) begin
         step(1'b0, 1'b0, 0, 32'd0);
         cmp("R7", "frozen outputs", int'({sh, sv, sd, sx, sy}), int'({hsync, vsync, de, x, y}));
      end

      // R9: mid-frame writes wait for the frame boundary
      scen = "R9";
      wr(4, 5, 3);
      wr(1, 3, 2);
      cmp("R9", "old width still live", int'(lv[0][4]), 8);
      run_frames(2, 1'b0);

      // R8: unused selects are ignored
      scen = "R8";
      wr(5, 16'hFFFF, 16'hFFFF);
      wr(6, 16'h1234, 16'h0);
      wr(7, 0, 0);
      run_frames(2, 1'b0);
      cmp("R8", "width after unused selects", int'(lv[0][4]), 5);

      // R11: zero-length blanking intervals
      scen = "R11";
      wr(0, 0, 0); wr(1, 0, 1); wr(2, 0, 0); wr(3, 0, 0); wr(4, 3, 2);
      run_frames(3, 1'b0);

      // R10: width clamp
      scen = "R10";
      wr(1, 0, 0); wr(4, 2000, 1);
      run_frames(1, 1'b1);
      maxx = 0;
      run_frames(1, 1'b1);
      cmp("R10", "largest x", maxx, 1365);
      // R10: height clamp
      wr(4, 1, 900);
      run_frames(1, 1'b1);
      maxy = 0;
      run_frames(1, 1'b1);
      cmp("R10", "largest y", maxy, 767);
      wr(4, 4, 3);
      run_frames(1, 1'b1);

      // random timing with writes scattered through frames
      scen = "random";
      for (int r = 0; r < 30; r++) begin
         for (int s = 0; s < 4; s++)
            wr(s, $urandom_range(0, 3), $urandom_range(0, 3));
         wr(4, $urandom_range(1, 5), $urandom_range(1, 5));
         run_frames(1, 1'b0);
         repeat ($urandom_range(0, 30)) step($urandom_range(0, 3) != 0, 1'b0, 0, 32'd0);
         wr($urandom_range(0, 7), $urandom_range(0, 3), $urandom_range(0, 3));
         run_frames(1, 1'b0);
      end

      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule